// File: doc/BRIEF.md
# Bus Lock Sequencer

This block sits beside a processor's bus unit and decides when the external bus-lock output is driven. For each accepted request it receives a decoded instruction class, a lock-prefix flag, a memory-destination flag, a misalignment flag and a code for an implicit system access. It then either raises an undefined-opcode exception or plays out the bus cycles the request needs, holding lock across all of them when the request calls for it.

Every instruction with a memory destination is handled as a read-modify-write. An operand that crosses a 4-byte boundary is split into two parts, so it takes two reads followed by two writes. Lock rises with the first bus cycle of a locked sequence. It stays high through bus stalls and across the read-to-write turn, and it falls on the clock edge that completes the final cycle. Implicit system accesses are always locked and ignore the instruction fields. These accesses are the interrupt acknowledge, the task busy-bit update, the descriptor load and the page-entry status update.

A request is taken on the edge where `req_valid` and `req_ready` are both high. `req_ready` is low, and `busy` high, from the edge that starts a bus sequence until the edge that completes its last cycle. A bus cycle is offered on `bus_valid` and completes on an edge where `bus_ready` is high.

Top module: `bus_lock_seq`

## Requirements
- R1: Reset, whether at start-up or in the middle of a sequence, returns the block to idle. In that state `bus_lock`, `busy`, `bus_valid` and `ud_exc` are 0 and `req_ready` is 1.
- R2: The lock prefix is legal only with a memory destination and only on kind codes 1 to 15. Those codes are 1 to 3 bit test-and-set/reset/complement, 4 exchange, 5 to 11 add, add-with-carry, subtract, subtract-with-borrow, and, or, xor, and 12 to 15 increment, decrement, not, negate. Such a request runs as a locked read-modify-write.
- R3: Any other prefixed instruction raises `ud_exc` for exactly the one cycle after acceptance and issues no bus cycle. This covers codes 0 and 16 to 31, and any code without a memory destination.
- R4: An exchange (code 4) with a memory destination is locked even without the prefix. Other unprefixed memory instructions run unlocked.
- R5: A memory-destination instruction issues its reads before its writes. An aligned operand takes one read and one write, both with `bus_part`=0. A misaligned operand takes two reads and then two writes, each pair with `bus_part` 0 then 1. An offered cycle holds its fields until `bus_ready`.
- R6: For a locked sequence `bus_lock` is high on every cycle in which a bus cycle is offered, stalls included, and it never drops between the read and write phases. It is low in the cycle after the final cycle completes.
- R7: System code 1 (interrupt acknowledge) issues two locked reads, with `bus_part` 0 and 1.
- R8: System code 2 (task busy bit) issues one locked read and then one locked write.
- R9: System code 3 (descriptor load) issues two locked reads, with `bus_part` 0 and 1.
- R10: System code 4 (page-entry status update) issues one locked read and then one locked write, both with `bus_bypass`=1. `bus_bypass` is 0 on every other cycle.
- R11: While a sequence runs, `busy` is 1 and `req_ready` is 0, and a held `req_valid` is not taken until the sequence has ended.
- R12: A system code from 1 to 4 overrides the instruction fields: a lock prefix on an illegal kind raises no exception. An unprefixed instruction without a memory destination is accepted with no bus cycle and no exception, and codes 5 to 7 count as no system access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_kind | input | 5 | Decoded instruction kind code |
| req_lock_pfx | input | 1 | Lock prefix present |
| req_mem_dst | input | 1 | Destination operand is in memory |
| req_misaligned | input | 1 | Operand crosses a 4-byte boundary |
| req_sys | input | 3 | Implicit system access code, 0 for none |
| bus_valid | output | 1 | Bus cycle offered |
| bus_ready | input | 1 | Bus cycle completes this edge |
| bus_write | output | 1 | 1 for a write cycle, 0 for a read |
| bus_part | output | 2 | Index of the cycle within its read or write phase |
| bus_bypass | output | 1 | Cycle must go straight to memory, past the translation cache |
| bus_lock | output | 1 | External bus lock |
| busy | output | 1 | Sequence in progress |
| ud_exc | output | 1 | Undefined-opcode exception pulse |

## Verification
On every cycle the assertions check the invariants that hold regardless of the request. Lock holds through stalls, and the first cycle of any sequence is a read. Offered cycles keep their fields while stalled, and requests are refused while busy. Bypass never appears without lock, and an exception cycle carries no bus cycle. Only the bench's reference model shows the content of each sequence for each kind and system code. That content covers the whitelist, the forced lock on exchange, the two-plus-two split for misaligned operands, and lock falling exactly one edge after the final write. The model also covers the case where reset lands in the middle of a locked sequence.

// File: rtl/bus_lock_pkg.sv
// Shared types and constants for the bus lock sequencer.
// Assumes a sequence needs at most three cycles per phase (CNT_W bits).
package bus_lock_pkg;

    localparam int CNT_W = 2;

    // Decoded instruction kinds as driven by the decoder.
    typedef enum logic [4:0] {
        OP_OTHER = 5'd0,
        OP_BTS   = 5'd1,
        OP_BTR   = 5'd2,
        OP_BTC   = 5'd3,
        OP_XCHG  = 5'd4,
        OP_ADD   = 5'd5,
        OP_ADC   = 5'd6,
        OP_SUB   = 5'd7,
        OP_SBB   = 5'd8,
        OP_AND   = 5'd9,
        OP_OR    = 5'd10,
        OP_XOR   = 5'd11,
        OP_INC   = 5'd12,
        OP_DEC   = 5'd13,
        OP_NOT   = 5'd14,
        OP_NEG   = 5'd15,
        OP_MOV   = 5'd16,
        OP_CMP   = 5'd17
    } op_kind_e;

    // Implicit system accesses that the processor itself starts.
    typedef enum logic [2:0] {
        SYS_NONE     = 3'd0,
        SYS_INTACK   = 3'd1,
        SYS_TASKBUSY = 3'd2,
        SYS_DESCLOAD = 3'd3,
        SYS_PTESTAT  = 3'd4
    } sys_kind_e;

    // Work order handed from the planner to the cycle sequencer.
    typedef struct packed {
        logic             illegal;
        logic             locked;
        logic             bypass;
        logic [CNT_W-1:0] n_rd;
        logic [CNT_W-1:0] n_wr;
    } seq_plan_t;

    // True for the kinds on which the lock prefix may appear.
    function automatic logic prefix_allowed(input logic [4:0] kind);
        case (kind)
            OP_BTS, OP_BTR, OP_BTC, OP_XCHG,
            OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_AND, OP_OR, OP_XOR,
            OP_INC, OP_DEC, OP_NOT, OP_NEG: return 1'b1;
            default:                        return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/bus_lock_plan.sv
// Request planner: turns one request into a work order (legality, lock,
// bypass, read and write counts). Purely combinational.
// Assumes: every memory-destination instruction is a read-modify-write;
// system codes outside the known set count as "none".
module bus_lock_plan
    import bus_lock_pkg::*;
#(
    parameter int INTACK_CYCLES = 2,
    parameter int DESC_WORDS    = 2,
    parameter int SPLIT_PARTS   = 2
) (
    input  logic [4:0] kind,
    input  logic       lock_pfx,
    input  logic       mem_dst,
    input  logic       misaligned,
    input  logic [2:0] sys,
    output seq_plan_t  plan
);

    localparam logic [CNT_W-1:0] INTACK_N = CNT_W'(INTACK_CYCLES);
    localparam logic [CNT_W-1:0] DESC_N   = CNT_W'(DESC_WORDS);
    localparam logic [CNT_W-1:0] SPLIT_N  = CNT_W'(SPLIT_PARTS);
    localparam logic [CNT_W-1:0] ONE_N    = CNT_W'(1);

    logic [CNT_W-1:0] parts;

    // Number of bus cycles per phase for an instruction operand.
    always_comb parts = misaligned ? SPLIT_N : ONE_N;

    // Build the work order; system accesses take priority over the instruction.
    always_comb begin
        plan = '0;
        case (sys)
            SYS_INTACK: begin
                plan.locked = 1'b1;
                plan.n_rd   = INTACK_N;
            end
            SYS_TASKBUSY: begin
                plan.locked = 1'b1;
                plan.n_rd   = ONE_N;
                plan.n_wr   = ONE_N;
            end
            SYS_DESCLOAD: begin
                plan.locked = 1'b1;
                plan.n_rd   = DESC_N;
            end
            SYS_PTESTAT: begin
                plan.locked = 1'b1;
                plan.bypass = 1'b1;
                plan.n_rd   = ONE_N;
                plan.n_wr   = ONE_N;
            end
            default: begin
                if (lock_pfx && !(prefix_allowed(kind) && mem_dst)) begin
                    plan.illegal = 1'b1;
                end else if (mem_dst) begin
                    plan.locked = lock_pfx || (kind == OP_XCHG);
                    plan.n_rd   = parts;
                    plan.n_wr   = parts;
                end
            end
        endcase
    end

endmodule

// File: rtl/bus_lock_fsm.sv
// Cycle sequencer: plays a loaded work order onto the bus as a read phase
// then a write phase, holding lock and bypass for the whole sequence.
// Assumes start is only raised while idle and with a non-zero read count.
module bus_lock_fsm
    import bus_lock_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] ld_rd,
    input  logic [CNT_W-1:0] ld_wr,
    input  logic             ld_lock,
    input  logic             ld_bypass,
    input  logic             bus_ready,
    output logic             bus_valid,
    output logic             bus_write,
    output logic [CNT_W-1:0] bus_part,
    output logic             bus_bypass,
    output logic             bus_lock,
    output logic             busy
);

    logic             active_q;
    logic             wr_phase_q;
    logic [CNT_W-1:0] remain_q;
    logic [CNT_W-1:0] part_q;
    logic [CNT_W-1:0] wr_total_q;
    logic             lock_q;
    logic             bypass_q;
    logic             last_in_phase;

    // The current cycle is the final one of its phase.
    always_comb last_in_phase = (remain_q <= CNT_W'(1));

    // Sequence state: load on start, advance on each completed bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q   <= 1'b0;
            wr_phase_q <= 1'b0;
            remain_q   <= '0;
            part_q     <= '0;
            wr_total_q <= '0;
            lock_q     <= 1'b0;
            bypass_q   <= 1'b0;
        end else if (!active_q) begin
            if (start) begin
                active_q   <= 1'b1;
                wr_phase_q <= 1'b0;
                remain_q   <= ld_rd;
                part_q     <= '0;
                wr_total_q <= ld_wr;
                lock_q     <= ld_lock;
                bypass_q   <= ld_bypass;
            end
        end else if (bus_ready) begin
            if (!last_in_phase) begin
                remain_q <= remain_q - CNT_W'(1);
                part_q   <= part_q + CNT_W'(1);
            end else if (!wr_phase_q && (wr_total_q != '0)) begin
                wr_phase_q <= 1'b1;
                remain_q   <= wr_total_q;
                part_q     <= '0;
            end else begin
                active_q   <= 1'b0;
                wr_phase_q <= 1'b0;
                remain_q   <= '0;
                part_q     <= '0;
                lock_q     <= 1'b0;
                bypass_q   <= 1'b0;
            end
        end
    end

    // Bus-facing view of the sequence state.
    always_comb begin
        bus_valid  = active_q;
        bus_write  = active_q && wr_phase_q;
        bus_part   = active_q ? part_q : '0;
        bus_lock   = active_q && lock_q;
        bus_bypass = active_q && bypass_q;
        busy       = active_q;
    end

endmodule

// File: rtl/bus_lock_seq.sv
// Bus lock sequencer top: accepts one request at a time, raises the
// undefined-opcode pulse for an illegal lock prefix, and otherwise hands
// the planned bus cycles to the sequencer.
// Assumes the bus unit keeps request fields stable while req_valid is high.
module bus_lock_seq
    import bus_lock_pkg::*;
#(
    parameter int INTACK_CYCLES = 2,
    parameter int DESC_WORDS    = 2,
    parameter int SPLIT_PARTS   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic [4:0] req_kind,
    input  logic       req_lock_pfx,
    input  logic       req_mem_dst,
    input  logic       req_misaligned,
    input  logic [2:0] req_sys,
    output logic       bus_valid,
    input  logic       bus_ready,
    output logic       bus_write,
    output logic [1:0] bus_part,
    output logic       bus_bypass,
    output logic       bus_lock,
    output logic       busy,
    output logic       ud_exc
);

    seq_plan_t        plan;
    logic             accept;
    logic             start;
    logic             ud_q;
    logic [CNT_W-1:0] part_w;

    bus_lock_plan #(
        .INTACK_CYCLES(INTACK_CYCLES),
        .DESC_WORDS   (DESC_WORDS),
        .SPLIT_PARTS  (SPLIT_PARTS)
    ) u_plan (
        .kind      (req_kind),
        .lock_pfx  (req_lock_pfx),
        .mem_dst   (req_mem_dst),
        .misaligned(req_misaligned),
        .sys       (req_sys),
        .plan      (plan)
    );

    // Handshake: a request is taken only while no sequence runs.
    always_comb begin
        req_ready = !busy;
        accept    = req_valid && req_ready;
        start     = accept && !plan.illegal && (plan.n_rd != '0);
    end

    bus_lock_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ld_rd     (plan.n_rd),
        .ld_wr     (plan.n_wr),
        .ld_lock   (plan.locked),
        .ld_bypass (plan.bypass),
        .bus_ready (bus_ready),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_part  (part_w),
        .bus_bypass(bus_bypass),
        .bus_lock  (bus_lock),
        .busy      (busy)
    );

    always_comb bus_part = 2'(part_w);

    // One-cycle exception pulse after an illegal request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) ud_q <= 1'b0;
        else        ud_q <= accept && plan.illegal;
    end

    always_comb ud_exc = ud_q;

endmodule

// File: rtl/bus_lock_seq_chk.sv
// Checker for the bus lock sequencer: cycle invariants on the top ports.
// Bound to every instance of bus_lock_seq.
module bus_lock_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic bus_valid,
    input logic bus_ready,
    input logic bus_write,
    input logic [1:0] bus_part,
    input logic bus_bypass,
    input logic bus_lock,
    input logic busy,
    input logic ud_exc
);

    // R6
    lock_stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_lock && bus_valid && !bus_ready) |=> bus_lock);

    // R6
    lock_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_lock |-> (busy && bus_valid));

    // R5
    first_is_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_valid) |-> !bus_write);

    // R5
    stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_write) && $stable(bus_part)));

    // R11
    no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

    // R10
    bypass_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_bypass |-> bus_lock);

    // R3
    ud_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ud_exc |-> !bus_valid);

    // R3
    ud_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ud_exc |=> !ud_exc);

endmodule

bind bus_lock_seq bus_lock_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_write (bus_write),
    .bus_part  (bus_part),
    .bus_bypass(bus_bypass),
    .bus_lock  (bus_lock),
    .busy      (busy),
    .ud_exc    (ud_exc)
);

// File: tb/bus_lock_seq_bench.sv
`timescale 1ns/1ps
module bus_lock_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [4:0] req_kind = '0;
    logic       req_lock_pfx = 1'b0;
    logic       req_mem_dst = 1'b0;
    logic       req_misaligned = 1'b0;
    logic [2:0] req_sys = '0;
    logic       bus_valid;
    logic       bus_ready = 1'b1;
    logic       bus_write;
    logic [1:0] bus_part;
    logic       bus_bypass;
    logic       bus_lock;
    logic       busy;
    logic       ud_exc;

    always #2 clk = ~clk;

    bus_lock_seq u_bus_lock_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_lock_pfx(req_lock_pfx), .req_mem_dst(req_mem_dst),
        .req_misaligned(req_misaligned), .req_sys(req_sys), .bus_valid(bus_valid),
        .bus_ready(bus_ready), .bus_write(bus_write), .bus_part(bus_part),
        .bus_bypass(bus_bypass), .bus_lock(bus_lock), .busy(busy), .ud_exc(ud_exc)
    );

    typedef struct { bit wr; int part; bit lk; bit by; } cyc_t;
    cyc_t  q[$];
    bit    ud_exp = 0;
    bit    acc_seen = 0;
    bit    stall_en = 0;
    bit    run_chk = 0;
    int    n_checks = 0;
    int    n_fail = 0;
    int    cycles = 0;
    string cur_tag = "R1";

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic void push(input bit wr, input int part, input bit lk, input bit by);
        cyc_t c;
        c.wr = wr; c.part = part; c.lk = lk; c.by = by;
        q.push_back(c);
    endfunction

    // Reference model: updated on each rising edge from the requirements.
    always @(posedge clk) begin
        bit was_busy;
        cycles++;
        if (!rst_n) begin
            q.delete();
            ud_exp = 0;
        end else begin
            was_busy = (q.size() != 0);
            ud_exp = 0;
            if (was_busy && bus_ready) void'(q.pop_front());
            if (!was_busy && req_valid) begin
                acc_seen = 1;
                case (req_sys)
                    3'd1, 3'd3: begin push(0, 0, 1, 0); push(0, 1, 1, 0); end
                    3'd2:       begin push(0, 0, 1, 0); push(1, 0, 1, 0); end
                    3'd4:       begin push(0, 0, 1, 1); push(1, 0, 1, 1); end
                    default: begin
                        bit legal_kind;
                        legal_kind = (req_kind >= 5'd1) && (req_kind <= 5'd15);
                        if (req_lock_pfx && !(legal_kind && req_mem_dst)) ud_exp = 1;
                        else if (req_mem_dst) begin
                            int n;
                            bit lk;
                            n  = req_misaligned ? 2 : 1;
                            lk = req_lock_pfx || (req_kind == 5'd4);
                            for (int i = 0; i < n; i++) push(0, i, lk, 0);
                            for (int i = 0; i < n; i++) push(1, i, lk, 0);
                        end
                    end
                endcase
            end
        end
    end

    // Per-cycle comparison against the model, then drive the bus response.
    always @(negedge clk) begin
        bit eb;
        if (rst_n && run_chk) begin
            eb = (q.size() != 0);
            chk(bus_valid === eb, cur_tag, "bus_valid", int'(bus_valid), int'(eb));
            chk(busy === eb, "R11", "busy", int'(busy), int'(eb));
            chk(req_ready === !eb, "R11", "req_ready", int'(req_ready), int'(!eb));
            chk(ud_exc === ud_exp, "R3", "ud_exc", int'(ud_exc), int'(ud_exp));
            if (eb) begin
                chk(bus_write === q[0].wr, cur_tag, "bus_write", int'(bus_write), int'(q[0].wr));
                chk(int'(bus_part) == q[0].part, cur_tag, "bus_part", int'(bus_part), q[0].part);
                chk(bus_lock === q[0].lk, "R6", "bus_lock", int'(bus_lock), int'(q[0].lk));
                chk(bus_bypass === q[0].by, "R10", "bus_bypass", int'(bus_bypass), int'(q[0].by));
            end else begin
                chk(bus_lock === 1'b0, "R6", "bus_lock idle", int'(bus_lock), 0);
                chk(bus_bypass === 1'b0, "R10", "bus_bypass idle", int'(bus_bypass), 0);
            end
        end
        bus_ready = stall_en ? ($urandom_range(0, 2) != 0) : 1'b1;
    end

    task automatic issue(input int kind, input bit pfx, input bit mem, input bit mis,
                         input int sys, input string tag);
        @(negedge clk);
        req_kind = 5'(kind); req_lock_pfx = pfx; req_mem_dst = mem;
        req_misaligned = mis; req_sys = 3'(sys);
        cur_tag = tag;
        acc_seen = 0;
        req_valid = 1'b1;
        do @(negedge clk); while (!acc_seen);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (q.size() != 0 || ud_exp) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(bus_lock === 1'b0, "R1", "lock in reset", int'(bus_lock), 0);
        chk(busy === 1'b0, "R1", "busy in reset", int'(busy), 0);
        chk(bus_valid === 1'b0, "R1", "valid in reset", int'(bus_valid), 0);
        chk(ud_exc === 1'b0, "R1", "ud in reset", int'(ud_exc), 0);
        chk(req_ready === 1'b1, "R1", "ready in reset", int'(req_ready), 1);
        rst_n = 1'b1;
        run_chk = 1;

        issue(5, 1, 1, 0, 0, "R2");  wait_idle();
        issue(1, 1, 1, 1, 0, "R2");  wait_idle();
        issue(15, 1, 1, 0, 0, "R2"); wait_idle();
        issue(16, 1, 1, 0, 0, "R3"); wait_idle();
        issue(5, 1, 0, 0, 0, "R3");  wait_idle();
        issue(17, 1, 1, 1, 0, "R3"); wait_idle();
        issue(4, 0, 1, 1, 0, "R4");  wait_idle();
        issue(7, 0, 1, 0, 0, "R4");  wait_idle();
        issue(9, 1, 1, 1, 0, "R5");  wait_idle();
        issue(16, 1, 0, 0, 1, "R7"); wait_idle();
        issue(0, 0, 0, 0, 2, "R8");  wait_idle();
        issue(0, 0, 0, 0, 3, "R9");  wait_idle();
        issue(0, 0, 0, 0, 4, "R10"); wait_idle();
        issue(12, 0, 0, 0, 0, "R12"); wait_idle();
        issue(20, 1, 1, 0, 5, "R12"); wait_idle();

        stall_en = 1;
        issue(11, 1, 1, 1, 0, "R6"); wait_idle();
        issue(4, 1, 1, 1, 0, "R6");
        issue(6, 1, 1, 1, 0, "R11");
        issue(0, 0, 0, 0, 4, "R11"); wait_idle();

        // R1: reset in the middle of a locked sequence
        issue(3, 1, 1, 1, 0, "R1");
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(bus_lock === 1'b0, "R1", "lock after mid reset", int'(bus_lock), 0);
        chk(busy === 1'b0, "R1", "busy after mid reset", int'(busy), 0);
        chk(bus_valid === 1'b0, "R1", "valid after mid reset", int'(bus_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 60; i++) begin
            int sys;
            sys = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 6)) : 0;
            issue(int'($urandom_range(0, 20)), bit'($urandom_range(0, 1)),
                  bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), sys, "R5");
        end
        wait_idle();

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        if (cycles > 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R11 actual=%0d expected=%0d", cycles, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule